// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block drives a three-wire serial EEPROM that stores 16-bit words. A host starts one command at a time by pulsing `start` while the block is idle, with a command code, a word address, a write word and a device-size bit. The block then frames the command on chip select, serial clock and serial data out, and for a read it samples serial data in. It raises `busy` for the whole transaction and pulses `done` in the cycle chip select falls. A read word appears on `rdata` from that pulse onward.

Four commands are supported, selected by `cmd`: read word (0), write word (1), write enable (2) and write disable (3). The bit period comes from an internal half-period divider counted in system clock cycles (`HALF_CYC`). After a write, the block holds `busy` for `WRITE_WAIT` cycles so the memory can finish programming. A write only takes effect in the memory if a write-enable command was sent earlier. The block never sends one on its own.

The controller has six named states. IDLE waits for a start. LEAD raises chip select for one half period. LOW drives the clock low and presents the current bit. HIGH raises the clock, and the read bit is taken on that rising edge. CLOSE drops chip select and pulses done. WRWAIT holds busy after a write. The transitions are: IDLE→LEAD on an accepted start. LEAD→LOW, LOW→HIGH and HIGH→LOW each happen when a half period expires. HIGH→CLOSE happens when a half period expires on the frame's last bit. CLOSE→WRWAIT follows a write frame. CLOSE→IDLE follows any other frame. WRWAIT→IDLE happens when the write-time count expires.

Top module: `uwire_eeprom_master`

## Requirements
- R1: Each frame begins with a 3-bit opcode sent most significant bit first: 110 for read, 101 for write, 100 for both write enable and write disable.
- R2: The address follows the opcode, most significant bit first. It is 6 bits (`addr[5:0]`) when `small_dev`=1 and 8 bits when `small_dev`=0.
- R3: Write enable sends an address field whose two top bits are 1 and whose remaining bits are 0. Write disable sends an all-zero address field. `addr` has no effect on either command.
- R4: A write frame sends 16 data bits, most significant bit first, right after the address and ends after the 16th. Enable and disable frames end right after the last address bit.
- R5: In a read, after the last address bit the block releases the data line (`ee_do_en`=0, `ee_do`=0). It then runs 16 more bit periods and samples `ee_di` on each rising `ee_sk`, most significant bit first. The word is on `rdata` from the `done` pulse.
- R6: Each bit period holds `ee_sk` low for `HALF_CYC` cycles and then high for `HALF_CYC` cycles. `ee_do` changes only while `ee_sk` is low.
- R7: `ee_cs` rises `2*HALF_CYC` cycles before the first rising `ee_sk` and falls when the last period ends. `ee_sk` is never high without `ee_cs`.
- R8: `done` is a one-cycle pulse in the cycle `ee_cs` is low again after a frame. `busy` is high from the cycle after an accepted start through that pulse.
- R9: After a write frame, `busy` stays high for exactly `WRITE_WAIT` cycles after the `done` cycle. After any other frame it falls in the next cycle.
- R10: A `start` seen while `busy` is high, including in the `done` cycle and during the write wait, is ignored: no frame is sent and the running frame is unchanged.
- R11: After reset, `ee_cs`, `ee_sk`, `ee_do`, `ee_do_en`, `busy`, `done` and `rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, taken only while idle |
| cmd | input | 2 | Command: 0 read, 1 write, 2 write enable, 3 write disable |
| addr | input | 8 | Word address (low 6 bits used for the small device) |
| wdata | input | 16 | Word to write |
| small_dev | input | 1 | 1 selects 6-bit addressing, 0 selects 8-bit |
| ee_di | input | 1 | Serial data from the memory |
| busy | output | 1 | Transaction or write wait in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata | output | 16 | Last word read |
| ee_cs | output | 1 | Chip select to the memory |
| ee_sk | output | 1 | Serial clock to the memory |
| ee_do | output | 1 | Serial data to the memory |
| ee_do_en | output | 1 | High while the block drives the data line |

## Verification
A new start request can coincide with the end of a frame. The cycle that pulses `done` is still busy, and so is every cycle of the write wait, so a start landing there must be dropped rather than begin a frame. The bench provokes this in two ways. It raises `start` in the exact `done` cycle of an enable frame, and it raises `start` repeatedly during a write's wait. It then judges the result by confirming that chip select stays low afterwards and that the count of frames seen on the wire equals the count of accepted commands. A start pulsed in the middle of a read is also checked. There, the scoreboard compares the full captured bit string, so any disturbance of the running frame shows up as a mismatch.

// File: rtl/uw_pkg.sv
package uw_pkg;

    typedef enum logic [1:0] {
        UW_READ  = 2'd0,
        UW_WRITE = 2'd1,
        UW_WREN  = 2'd2,
        UW_WRDIS = 2'd3
    } uw_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_LOW,
        S_HIGH,
        S_CLOSE,
        S_WRWAIT
    } uw_state_e;

    localparam logic [2:0] OPC_READ  = 3'b110;
    localparam logic [2:0] OPC_WRITE = 3'b101;
    localparam logic [2:0] OPC_WEN   = 3'b100;

endpackage

// File: rtl/uw_tick_counter.sv
module uw_tick_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R6: the divider never runs past its period
    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) < LIMIT);

endmodule

// File: rtl/uw_frame_shift.sv
module uw_frame_shift
    import uw_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int SMALL_AW = 6,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [1:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              small_dev,
    input  logic              advance,
    input  logic              sample,
    input  logic              ee_di,
    output logic              tx_bit,
    output logic              last_bit,
    output logic              rx_phase,
    output logic              wr_frame,
    output logic [DATA_W-1:0] rdata
);
    localparam int OP_W    = $bits(OPC_READ);
    localparam int FRAME_W = OP_W + ADDR_W + DATA_W;
    localparam int IDX_W   = $clog2(FRAME_W + 1);
    localparam int PAD     = ADDR_W - SMALL_AW;

    logic [FRAME_W-1:0]  tx_sr, frame_nx;
    logic [IDX_W-1:0]    bit_idx, nbits, hdr_len, nbits_nx, hdr_nx;
    logic                is_read;
    logic [DATA_W-1:0]   rx_sr;
    logic [OP_W-1:0]     opc;
    logic [ADDR_W-1:0]   af_l;
    logic [SMALL_AW-1:0] af_s;
    uw_cmd_e             c;

    always_comb begin
        c = uw_cmd_e'(cmd);
        unique case (c)
            UW_READ:  opc = OPC_READ;
            UW_WRITE: opc = OPC_WRITE;
            default:  opc = OPC_WEN;
        endcase
        unique case (c)
            UW_WREN: begin
                af_l = {2'b11, {(ADDR_W-2){1'b0}}};
                af_s = {2'b11, {(SMALL_AW-2){1'b0}}};
            end
            UW_WRDIS: begin
                af_l = '0;
                af_s = '0;
            end
            default: begin
                af_l = addr;
                af_s = addr[SMALL_AW-1:0];
            end
        endcase
        if (small_dev) begin
            frame_nx = FRAME_W'({opc, af_s, wdata}) << PAD;
            hdr_nx   = IDX_W'(OP_W + SMALL_AW);
        end else begin
            frame_nx = {opc, af_l, wdata};
            hdr_nx   = IDX_W'(OP_W + ADDR_W);
        end
        nbits_nx = ((c == UW_READ) || (c == UW_WRITE)) ? hdr_nx + IDX_W'(DATA_W) : hdr_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr    <= '0;
            bit_idx  <= '0;
            nbits    <= IDX_W'(OP_W);
            hdr_len  <= IDX_W'(OP_W);
            is_read  <= 1'b0;
            wr_frame <= 1'b0;
            rx_sr    <= '0;
        end else begin
            if (load) begin
                tx_sr    <= frame_nx;
                bit_idx  <= '0;
                nbits    <= nbits_nx;
                hdr_len  <= hdr_nx;
                is_read  <= (c == UW_READ);
                wr_frame <= (c == UW_WRITE);
                if (c == UW_READ) rx_sr <= '0;
            end else if (advance) begin
                tx_sr   <= tx_sr << 1;
                bit_idx <= bit_idx + IDX_W'(1);
            end
            if (sample) begin
                rx_sr <= {rx_sr[DATA_W-2:0], ee_di};
            end
        end
    end

    assign tx_bit   = tx_sr[FRAME_W-1];
    assign last_bit = (bit_idx == nbits - IDX_W'(1));
    assign rx_phase = is_read && (bit_idx >= hdr_len);
    assign rdata    = rx_sr;

    // R4: the bit index stays inside the frame length chosen at load
    assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx < nbits);

endmodule

// File: rtl/uw_ctrl_fsm.sv
module uw_ctrl_fsm
    import uw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic half_tick,
    input  logic wait_tick,
    input  logic last_bit,
    input  logic rx_phase,
    input  logic wr_frame,
    input  logic tx_bit,
    output logic load,
    output logic advance,
    output logic sample,
    output logic half_en,
    output logic wait_en,
    output logic busy,
    output logic done,
    output logic ee_cs,
    output logic ee_sk,
    output logic ee_do,
    output logic ee_do_en
);
    uw_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start)     state_nx = S_LEAD;
            S_LEAD:   if (half_tick) state_nx = S_LOW;
            S_LOW:    if (half_tick) state_nx = S_HIGH;
            S_HIGH:   if (half_tick) state_nx = last_bit ? S_CLOSE : S_LOW;
            S_CLOSE:  state_nx = wr_frame ? S_WRWAIT : S_IDLE;
            S_WRWAIT: if (wait_tick) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        load     = 1'b0;
        advance  = 1'b0;
        sample   = 1'b0;
        half_en  = 1'b0;
        wait_en  = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        ee_cs    = 1'b0;
        ee_sk    = 1'b0;
        ee_do    = 1'b0;
        ee_do_en = 1'b0;
        unique case (state)
            S_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            S_LEAD: begin
                half_en  = 1'b1;
                ee_cs    = 1'b1;
                ee_do_en = 1'b1;
            end
            S_LOW: begin
                half_en  = 1'b1;
                ee_cs    = 1'b1;
                ee_do_en = !rx_phase;
                ee_do    = !rx_phase && tx_bit;
                sample   = half_tick && rx_phase;
            end
            S_HIGH: begin
                half_en  = 1'b1;
                ee_cs    = 1'b1;
                ee_sk    = 1'b1;
                ee_do_en = !rx_phase;
                ee_do    = !rx_phase && tx_bit;
                advance  = half_tick && !last_bit;
            end
            S_CLOSE:  done = 1'b1;
            S_WRWAIT: wait_en = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // R8: done lasts one cycle
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: done arrives while busy with chip select already low
    assert_done_cs_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !ee_cs));

endmodule

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master
    import uw_pkg::*;
#(
    parameter int HALF_CYC   = 4,
    parameter int WRITE_WAIT = 20,
    parameter int ADDR_W     = 8,
    parameter int SMALL_AW   = 6,
    parameter int DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              small_dev,
    input  logic              ee_di,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_do,
    output logic              ee_do_en
);
    logic load, advance, sample, half_en, wait_en;
    logic half_tick, wait_tick;
    logic tx_bit, last_bit, rx_phase, wr_frame;

    uw_tick_counter #(.LIMIT(HALF_CYC)) u_half (
        .clk(clk), .rst_n(rst_n), .en(half_en), .tick(half_tick)
    );

    uw_tick_counter #(.LIMIT(WRITE_WAIT)) u_wrwait (
        .clk(clk), .rst_n(rst_n), .en(wait_en), .tick(wait_tick)
    );

    uw_frame_shift #(
        .ADDR_W(ADDR_W), .SMALL_AW(SMALL_AW), .DATA_W(DATA_W)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .cmd(cmd), .addr(addr),
        .wdata(wdata), .small_dev(small_dev), .advance(advance),
        .sample(sample), .ee_di(ee_di), .tx_bit(tx_bit),
        .last_bit(last_bit), .rx_phase(rx_phase), .wr_frame(wr_frame),
        .rdata(rdata)
    );

    uw_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .half_tick(half_tick),
        .wait_tick(wait_tick), .last_bit(last_bit), .rx_phase(rx_phase),
        .wr_frame(wr_frame), .tx_bit(tx_bit), .load(load),
        .advance(advance), .sample(sample), .half_en(half_en),
        .wait_en(wait_en), .busy(busy), .done(done), .ee_cs(ee_cs),
        .ee_sk(ee_sk), .ee_do(ee_do), .ee_do_en(ee_do_en)
    );

    // R7: no serial clock outside chip select
    assert_sk_under_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);
    // R5: an undriven data line carries zero
    assert_do_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_do_en |-> !ee_do);
    // R6: data is steady across the rising clock
    assert_do_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sk) |-> $stable(ee_do));

endmodule

// File: tb/sim_uwire_eeprom_master.sv
module sim_uwire_eeprom_master;
    localparam int HALF = 3;
    localparam int WW   = 12;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic [7:0]  addr = 8'd0;
    logic [15:0] wdata = 16'd0;
    logic        small_dev = 1'b0;
    logic        ee_di = 1'b1;
    logic        busy, done, ee_cs, ee_sk, ee_do, ee_do_en;
    logic [15:0] rdata;

    uwire_eeprom_master #(.HALF_CYC(HALF), .WRITE_WAIT(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr),
        .wdata(wdata), .small_dev(small_dev), .ee_di(ee_di), .busy(busy),
        .done(done), .rdata(rdata), .ee_cs(ee_cs), .ee_sk(ee_sk),
        .ee_do(ee_do), .ee_do_en(ee_do_en)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        int          nb;
        logic [63:0] bits;
        bit          rd;
        bit          wr;
        logic [15:0] word;
    } exp_t;
    exp_t sbq[$];

    // memory model
    logic [63:0] cap;
    int          ncap, nrel, nframes, nissued;
    logic [15:0] slave_word;
    int          slave_start;
    bit          slave_rd;

    initial begin
        cap = '0; ncap = 0; nrel = 0; nframes = 0; nissued = 0;
        slave_word = '0; slave_start = 0; slave_rd = 0;
    end

    always @(posedge ee_cs) begin
        cap = '0; ncap = 0; nrel = 0; nframes++;
    end

    always @(posedge ee_sk) begin
        cap = {cap[62:0], ee_do};
        if (!ee_do_en) nrel++;
        ncap++;
    end

    always @(negedge ee_sk) begin
        if (ee_cs) begin
            int k;
            k = ncap - slave_start;
            if (slave_rd && k >= 0 && k < 16) ee_di = slave_word[15-k];
            else ee_di = 1'b1;
        end
    end

    // timing tracker and scoreboard monitor
    int   since_cs, lead, hi_run, busy_cnt, exp_ww;
    bit   seen_rise, hi_bad, busy_track;
    logic psk, pcs;
    initial begin
        since_cs = 0; lead = 0; hi_run = 0; busy_cnt = 0; exp_ww = 0;
        seen_rise = 0; hi_bad = 0; busy_track = 0; psk = 0; pcs = 0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (ee_cs && !pcs) begin
                since_cs = 0; seen_rise = 0; hi_bad = 0; hi_run = 0;
            end
            if (ee_cs) since_cs++;
            if (ee_sk && !psk && !seen_rise) begin
                lead = since_cs - 1;
                seen_rise = 1;
            end
            if (ee_sk) hi_run++;
            if (!ee_sk && psk) begin
                if (hi_run != HALF) hi_bad = 1;
                hi_run = 0;
            end
            psk = ee_sk;
            pcs = ee_cs;

            if (busy_track) begin
                if (busy) busy_cnt++;
                else begin
                    check(busy_cnt == exp_ww, "R9", "busy cycles after done", busy_cnt, exp_ww);
                    busy_track = 0;
                end
            end
            if (done) begin
                if (sbq.size() == 0) begin
                    check(0, "R10", "done with no queued command", 1, 0);
                end else begin
                    exp_t e;
                    logic [63:0] m;
                    e = sbq.pop_front();
                    m = (64'd1 << e.nb) - 64'd1;
                    check(ncap == e.nb, "R4", "frame bit count", ncap, e.nb);
                    check((cap & m) == e.bits, "R1 R2 R3", "frame bits", cap & m, e.bits);
                    check(nrel == (e.rd ? 16 : 0), "R5", "released periods", nrel, e.rd ? 16 : 0);
                    if (e.rd) check(rdata == e.word, "R5", "read word", rdata, e.word);
                    check(lead == 2*HALF, "R7", "cs to first sk rise", lead, 2*HALF);
                    check(!hi_bad, "R6", "sk high length", hi_bad, 0);
                    check(busy && !ee_cs, "R8", "busy/cs at done", {busy, ee_cs}, 2'b10);
                    exp_ww = e.wr ? WW : 0;
                    busy_cnt = 0;
                    busy_track = 1;
                end
            end
        end
    end

    // driver: pushes expected frame and issues the command
    task automatic issue(input int c, input logic [7:0] a, input logic [15:0] d,
                         input bit sm, input logic [15:0] word, input bit wait_end);
        exp_t e;
        logic [2:0] op;
        logic [7:0] af;
        int alen;
        while (busy || busy_track) @(negedge clk);
        alen = sm ? 6 : 8;
        op = (c == 0) ? 3'b110 : (c == 1) ? 3'b101 : 3'b100;
        af = (c == 2) ? (sm ? 8'h30 : 8'hC0) : (c == 3) ? 8'h00 : a;
        e.bits = '0; e.nb = 0;
        for (int i = 2; i >= 0; i--) begin e.bits = {e.bits[62:0], op[i]}; e.nb++; end
        for (int i = alen-1; i >= 0; i--) begin e.bits = {e.bits[62:0], af[i]}; e.nb++; end
        if (c == 1) for (int i = 15; i >= 0; i--) begin e.bits = {e.bits[62:0], d[i]}; e.nb++; end
        if (c == 0) for (int i = 15; i >= 0; i--) begin e.bits = {e.bits[62:0], 1'b0}; e.nb++; end
        e.rd = (c == 0);
        e.wr = (c == 1);
        e.word = word;
        sbq.push_back(e);
        slave_word = word;
        slave_start = 3 + alen;
        slave_rd = (c == 0);
        nissued++;
        cmd = 2'(c); addr = a; wdata = d; small_dev = sm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (wait_end) begin
            while (busy || busy_track) @(negedge clk);
        end
    endtask

    task automatic check_quiet(input string tag, input int cycles);
        int hi = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (ee_cs || busy) hi++;
        end
        check(hi == 0, tag, "no frame after ignored start", hi, 0);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(0, "WDOG", "watchdog expired", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check({ee_cs, ee_sk, ee_do, ee_do_en, busy, done} == 6'b0, "R11", "outputs in reset",
              {ee_cs, ee_sk, ee_do, ee_do_en, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rdata == 16'h0 && !busy && !ee_cs, "R11", "state after reset", rdata, 0);

        // R3: enable with both sizes, addr ignored
        issue(2, 8'h5A, 16'h0, 1'b1, 16'h0, 1);
        issue(2, 8'h5A, 16'h0, 1'b0, 16'h0, 1);
        // R4: writes, 8-bit then 6-bit with upper address bits set
        issue(1, 8'hA5, 16'h1234, 1'b0, 16'h0, 1);
        issue(1, 8'hFF, 16'hBEEF, 1'b1, 16'h0, 1);
        // R5: reads with different words and sizes
        issue(0, 8'h81, 16'h0, 1'b0, 16'hC3A5, 1);
        issue(0, 8'h15, 16'h0, 1'b1, 16'h0001, 1);
        issue(0, 8'h7E, 16'h0, 1'b0, 16'hFFFF, 1);
        issue(0, 8'h2A, 16'h0, 1'b1, 16'h8000, 1);
        // R3: disable ignores addr
        issue(3, 8'hFF, 16'hFFFF, 1'b0, 16'h0, 1);
        issue(3, 8'hFF, 16'hFFFF, 1'b1, 16'h0, 1);

        // R10: start during a running read
        issue(0, 8'h3C, 16'h0, 1'b0, 16'h5AA5, 0);
        repeat (4*HALF) @(negedge clk);
        cmd = 2'd1; addr = 8'h11; wdata = 16'hDEAD; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy || busy_track) @(negedge clk);

        // R10: start in the done cycle of an enable frame
        issue(2, 8'h00, 16'h0, 1'b0, 16'h0, 0);
        while (!done) @(negedge clk);
        cmd = 2'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_quiet("R10", 4*HALF);

        // R10: start held during write wait
        issue(1, 8'h42, 16'h0F0F, 1'b0, 16'h0, 0);
        while (!done) @(negedge clk);
        @(negedge clk);
        cmd = 2'd0; start = 1'b1;
        repeat (WW - 2) @(negedge clk);
        start = 1'b0;
        while (busy || busy_track) @(negedge clk);
        check_quiet("R10", 4*HALF);

        check(nframes == nissued, "R10", "frames on wire", nframes, nissued);
        check(sbq.size() == 0, "R8", "unfinished commands", sbq.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule